// File: doc/BRIEF.md
# Endian Lane Mapper

This block sits on the outbound path from a big-endian processor-side bus to a little-endian 32-bit peripheral data bus. On the processor side, byte 0 (the lowest address) travels in the most significant bits of the word. On the little-endian side, lane k carries the byte at word offset k. A 64-bit source beat arrives with eight byte enables and a policy bit. The block captures the beat and sends it as two 32-bit beats, using a valid/ready handshake on both sides.

Two lane policies are available. The address-keeping policy puts each byte on the lane that matches its byte address. The value-keeping policy copies each aligned 4-byte word straight across, bit for bit, so the word's numeric value survives. This also means the first byte of the word appears at offset 3. The byte enables follow exactly the same permutation as the data. The mapping works per aligned word only and knows nothing about the sizes of the items inside a word.

Top module: `elm_lane_mapper`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1. A `in_swap` value of 0 selects the address-keeping policy.
- R2: Address-keeping policy: the processor byte at word offset k is bits [31-8k -: 8] of the processor word. It appears on `out_data[8k+7:8k]`.
- R3: Value-keeping policy: `out_data` equals the processor word bit for bit. Processor byte 0 therefore sits on `out_data[31:24]`, which is offset 3.
- R4: Bit 3-k of a word's enables belongs to offset k. It is mapped to `out_be` with the same permutation as the data. It lands in `out_be[k]` under address keeping and in `out_be[3-k]` under value keeping.
- R5: A 64-bit beat leaves as two words in address order. `in_data[63:32]` with `in_be[7:4]` goes first, then `in_data[31:0]` with `in_be[3:0]`.
- R6: The policy is captured when a beat is accepted and applies to both of its words. Changing `in_swap` while a beat is being sent has no effect on that beat.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_be` stay unchanged and `out_valid` stays 1.
- R8: No beat is lost or duplicated. A new beat can be accepted in the same cycle that the second word of the current beat is taken, so a steady stream keeps one output word per cycle.
- R9: Under value keeping, an 8-byte quantity has each 4-byte half kept separately. For example, 0x1122334455667788 leaves as 0x11223344 and then 0x55667788.
- R10: Under value keeping, a lone byte at offset 0 (word enables 4'b1000) leaves with `out_be` 4'b1000 on lane [31:24]. A halfword at offset 0 (enables 4'b1100) leaves with `out_be` 4'b1100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Processor-side beat is valid |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | 64 | Processor-side beat, byte 0 in bits [63:56] |
| in_be | input | 8 | Byte enables, active high, bit 7 for byte 0 |
| in_swap | input | 1 | Policy: 0 keeps addresses, 1 keeps word values |
| out_valid | output | 1 | Little-endian word is valid |
| out_ready | input | 1 | Downstream takes the word this cycle |
| out_data | output | 32 | Little-endian word, lane k at bits [8k+7:8k] |
| out_be | output | 4 | Lane enables, bit k for lane k |

## Verification
A beat accepted at one clock edge shows its first word on the outputs right after that edge. Its second word follows the edge at which the first word is taken. A stalled word must be the same at every later edge until it is taken. The bench pushes both expected words into a scoreboard queue at the moment it sees `in_ready` high, and samples the outputs at falling edges. At each falling edge it pops one entry exactly when `out_valid` and the `out_ready` it has just driven are both 1, so each comparison lines up with the edge that transfers that word. Throughput is checked by counting the cycles a back-to-back stream of four beats needs to drain.

// File: rtl/elm_pkg.sv
// Shared definitions for the endian lane mapper.
// Assumes byte-granular lanes; the policy encoding matches the in_swap pin.
package elm_pkg;

    typedef enum logic {
        POL_ADDR_KEEP  = 1'b0,   // each byte stays at its own address
        POL_VALUE_KEEP = 1'b1    // each aligned word keeps its numeric value
    } lane_policy_e;

endpackage

// File: rtl/elm_beat_hold.sv
// Holds one wide source beat and steps through its words in address order.
// Assumes the lowest-addressed word sits in the most significant bits of the beat.
// The policy is captured with the beat, so both of its words share one mapping.
module elm_beat_hold
    import elm_pkg::*;
#(
    parameter int BEAT_W     = 64,
    parameter int BEAT_BYTES = 8,
    parameter int WORDS      = 2,
    parameter int IDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [BEAT_W-1:0]     in_data,
    input  logic [BEAT_BYTES-1:0] in_be,
    input  logic                  in_swap,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [BEAT_W-1:0]     beat_q,
    output logic [BEAT_BYTES-1:0] be_q,
    output lane_policy_e          policy_q,
    output logic [IDX_W-1:0]      idx_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    logic full_q;
    logic last_word;
    logic in_fire;
    logic out_fire;

    // Handshake decode: refill is allowed as the final word leaves.
    always_comb begin
        last_word = (idx_q == LAST_IDX);
        out_fire  = full_q && out_ready;
        in_ready  = !full_q || (out_ready && last_word);
        in_fire   = in_valid && in_ready;
        out_valid = full_q;
    end

    // Occupancy and word index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            idx_q  <= '0;
        end else if (in_fire) begin
            full_q <= 1'b1;
            idx_q  <= '0;
        end else if (out_fire) begin
            if (last_word) begin
                full_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Beat, enable and policy capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q   <= '0;
            be_q     <= '0;
            policy_q <= POL_ADDR_KEEP;
        end else if (in_fire) begin
            beat_q   <= in_data;
            be_q     <= in_be;
            policy_q <= lane_policy_e'(in_swap);
        end
    end

    AST_LOAD_STARTS_AT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) in_fire |=> (out_valid && idx_q == '0)); // R5
    AST_NEXT_WORD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (out_fire && !last_word) |=> (out_valid && idx_q == $past(idx_q) + 1'b1)); // R5
    AST_POLICY_HELD: assert property (@(posedge clk) disable iff (!rst_n) (full_q && !in_fire) |=> ($stable(policy_q) && $stable(beat_q))); // R6
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n) (full_q && !out_ready) |-> !in_ready); // R8

endmodule

// File: rtl/elm_word_pick.sv
// Selects one word and its enables from the held beat by word index.
// Assumes word 0 is the lowest-addressed word in the top bits of the beat.
module elm_word_pick #(
    parameter int LANE_W     = 32,
    parameter int LANE_BYTES = 4,
    parameter int WORDS      = 2,
    parameter int IDX_W      = 1
) (
    input  logic [LANE_W*WORDS-1:0]     beat_i,
    input  logic [LANE_BYTES*WORDS-1:0] be_i,
    input  logic [IDX_W-1:0]            idx_i,
    output logic [LANE_W-1:0]           word_o,
    output logic [LANE_BYTES-1:0]       be_o
);

    localparam int BEAT_W     = LANE_W * WORDS;
    localparam int BEAT_BYTES = LANE_BYTES * WORDS;

    logic [LANE_W-1:0]     words [WORDS];
    logic [LANE_BYTES-1:0] bes   [WORDS];

    // Slice the beat into words in address order.
    for (genvar i = 0; i < WORDS; i++) begin : g_slice
        assign words[i] = beat_i[BEAT_W-1-i*LANE_W -: LANE_W];
        assign bes[i]   = be_i[BEAT_BYTES-1-i*LANE_BYTES -: LANE_BYTES];
    end

    // Index-driven word select.
    always_comb begin
        word_o = words[idx_i];
        be_o   = bes[idx_i];
    end

endmodule

// File: rtl/elm_lane_map.sv
// Maps one processor-side word and its enables onto little-endian lanes.
// Address keeping reverses byte order relative to the big-endian bit numbering;
// value keeping passes the word through so its numeric value is unchanged.
module elm_lane_map
    import elm_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int LANE_BYTES = 4
) (
    input  lane_policy_e                 policy_i,
    input  logic [BYTE_W*LANE_BYTES-1:0] word_i,
    input  logic [LANE_BYTES-1:0]        be_i,
    output logic [BYTE_W*LANE_BYTES-1:0] word_o,
    output logic [LANE_BYTES-1:0]        be_o
);

    localparam int LANE_W = BYTE_W * LANE_BYTES;

    logic [LANE_W-1:0]     addr_word;
    logic [LANE_BYTES-1:0] addr_be;

    // Lane k receives the byte at offset k, which is big-endian slot LANE_BYTES-1-k.
    for (genvar k = 0; k < LANE_BYTES; k++) begin : g_lane
        assign addr_word[k*BYTE_W +: BYTE_W] = word_i[(LANE_BYTES-1-k)*BYTE_W +: BYTE_W];
        assign addr_be[k]                    = be_i[LANE_BYTES-1-k];
    end

    // Policy select for data and enables together.
    always_comb begin
        if (policy_i == POL_VALUE_KEEP) begin
            word_o = word_i;
            be_o   = be_i;
        end else begin
            word_o = addr_word;
            be_o   = addr_be;
        end
    end

endmodule

// File: rtl/elm_lane_mapper.sv
// Outbound big-endian to little-endian lane mapper.
// Accepts a wide beat with enables and a policy bit, and emits it as
// lane-mapped words in address order over a valid/ready handshake.
module elm_lane_mapper
    import elm_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int LANE_BYTES = 4,
    parameter int WORDS      = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [BYTE_W*LANE_BYTES*WORDS-1:0] in_data,
    input  logic [LANE_BYTES*WORDS-1:0]    in_be,
    input  logic                           in_swap,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [BYTE_W*LANE_BYTES-1:0]   out_data,
    output logic [LANE_BYTES-1:0]          out_be
);

    localparam int LANE_W     = BYTE_W * LANE_BYTES;
    localparam int BEAT_W     = LANE_W * WORDS;
    localparam int BEAT_BYTES = LANE_BYTES * WORDS;
    localparam int IDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [BEAT_W-1:0]     beat_q;
    logic [BEAT_BYTES-1:0] be_q;
    lane_policy_e          policy_q;
    logic [IDX_W-1:0]      idx_q;
    logic [LANE_W-1:0]     pick_word;
    logic [LANE_BYTES-1:0] pick_be;

    elm_beat_hold #(
        .BEAT_W     (BEAT_W),
        .BEAT_BYTES (BEAT_BYTES),
        .WORDS      (WORDS),
        .IDX_W      (IDX_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_be     (in_be),
        .in_swap   (in_swap),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .beat_q    (beat_q),
        .be_q      (be_q),
        .policy_q  (policy_q),
        .idx_q     (idx_q)
    );

    elm_word_pick #(
        .LANE_W     (LANE_W),
        .LANE_BYTES (LANE_BYTES),
        .WORDS      (WORDS),
        .IDX_W      (IDX_W)
    ) u_pick (
        .beat_i (beat_q),
        .be_i   (be_q),
        .idx_i  (idx_q),
        .word_o (pick_word),
        .be_o   (pick_be)
    );

    elm_lane_map #(
        .BYTE_W     (BYTE_W),
        .LANE_BYTES (LANE_BYTES)
    ) u_map (
        .policy_i (policy_q),
        .word_i   (pick_word),
        .be_i     (pick_be),
        .word_o   (out_data),
        .be_o     (out_be)
    );

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be))); // R7
    AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> ($countones(out_be) == $countones(pick_be))); // R4
    AST_VALUE_PASS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && policy_q == POL_VALUE_KEEP) |-> (out_data == pick_word)); // R3

endmodule

// File: tb/elm_lane_mapper_tb.sv
// Scoreboard bench: the driver queues expected words, the monitor pops and compares.
module elm_lane_mapper_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic [7:0]  in_be = '0;
    logic        in_swap = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_be;

    elm_lane_mapper u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_be     (in_be),
        .in_swap   (in_swap),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_be    (out_be)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] data;
        logic [3:0]  be;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    exp_t        e;
    int          n_tests = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          fire_cnt = 0;
    int          stall_mode = 0;
    logic [31:0] lfsr = 32'hACE1_1234;
    logic        prev_hold = 1'b0;
    logic [31:0] prev_data = '0;
    logic [3:0]  prev_be = '0;

    // Expected lane data from the requirements: offset k on lane k, or word unchanged.
    function automatic logic [31:0] lane_data(input logic [31:0] w, input logic s);
        return s ? w : {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [3:0] lane_be(input logic [3:0] b, input logic s);
        return s ? b : {b[0], b[1], b[2], b[3]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Driver: called at a falling edge; queues both words once the beat is taken.
    task automatic send(input logic [63:0] d, input logic [7:0] b, input logic s, input string tag);
        in_valid = 1'b1;
        in_data  = d;
        in_be    = b;
        in_swap  = s;
        #(CLK_PERIOD/4);
        while (!in_ready) begin
            @(negedge clk);
            #(CLK_PERIOD/4);
        end
        sb.push_back('{lane_data(d[63:32], s), lane_be(b[7:4], s), tag});
        sb.push_back('{lane_data(d[31:0], s), lane_be(b[3:0], s), tag});
        @(negedge clk);
        in_valid = 1'b0;
        in_swap  = ~s;   // R6: flip the policy while the beat is still being sent
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog and cycle count.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    // Monitor: stall-hold check, ready pattern, then scoreboard pop on transfer.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold) begin
                chk(out_valid && out_data == prev_data && out_be == prev_be, "R7 held word",
                    {27'd0, out_valid, out_data, out_be}, {27'd0, 1'b1, prev_data, prev_be});
            end
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (stall_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = ~out_ready;
                default: out_ready = lfsr[2] | lfsr[5];
            endcase
            if (out_valid && out_ready) begin
                fire_cnt++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 unexpected word", {28'd0, out_data, out_be}, 64'd0);
                end else begin
                    e = sb.pop_front();
                    chk(out_data == e.data && out_be == e.be, e.tag,
                        {28'd0, out_data, out_be}, {28'd0, e.data, e.be});
                end
            end
            prev_hold = out_valid && !out_ready;
            prev_data = out_data;
            prev_be   = out_be;
        end
    end

    initial begin
        int t0;
        int c0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", {63'd0, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", {63'd0, out_valid}, 64'd0);

        // R2 R5: address keeping, full enables
        stall_mode = 0;
        send(64'h0123_4567_89AB_CDEF, 8'hFF, 1'b0, "R2 R5 address keeping");
        // R3: value keeping
        send(64'h0123_4567_89AB_CDEF, 8'hFF, 1'b1, "R3 value keeping");
        // R9: 8-byte quantity halves kept separately -> 0x11223344 then 0x55667788
        send(64'h1122_3344_5566_7788, 8'hFF, 1'b1, "R9 doubleword halves");
        // R10: lone byte and halfword at offset 0 under value keeping
        send(64'hAA00_0000_BBCC_0000, 8'b1000_1100, 1'b1, "R10 byte and halfword");
        // R4: same partial enables under address keeping -> 0001 and 0011
        send(64'hAA00_0000_BBCC_0000, 8'b1000_1100, 1'b0, "R4 partial enables");
        send(64'h00DD_EE00_0000_00FF, 8'b0110_0001, 1'b0, "R4 middle enables");
        drain();

        // R6 R7: stalls while the policy pin toggles mid-beat
        stall_mode = 1;
        send(64'hCAFE_F00D_1357_9BDF, 8'hF0, 1'b1, "R6 policy captured");
        send(64'h0246_8ACE_FDB9_7531, 8'h0F, 1'b0, "R6 policy captured");
        drain();

        // R7 R8: random stream with random stalls
        stall_mode = 2;
        for (int i = 0; i < 20; i++) begin
            send({lfsr, ~{lfsr[15:0], lfsr[31:16]}}, lfsr[11:4], lfsr[9], "R8 stream");
        end
        drain();

        // R8: back-to-back beats keep one word per cycle
        stall_mode = 0;
        @(negedge clk);
        t0 = cyc;
        c0 = fire_cnt;
        for (int i = 0; i < 4; i++) begin
            send(64'h1000_0000_2000_0000 + 64'(i), 8'hFF, i[0], "R8 back to back");
        end
        drain();
        chk((fire_cnt - c0 == 8) && (cyc - t0 <= 10), "R8 throughput",
            64'(cyc - t0), 64'd10);

        summary();
        $finish;
    end

endmodule